// File: doc/BRIEF.md
# Speculative Reorder Buffer

This block keeps issued instructions in program order while they execute out of order, and retires them strictly in that order. Each issued instruction takes one slot in a circular buffer. The slot index goes back to the issuer as the tag under which the instruction's result will later appear. A small rename table maps each architectural register to the slot that will produce its newest value. A lookup port lets the operand stage ask whether a register is waiting on a slot, and which one.

Results arrive on a tagged result bus and are captured speculatively into their slots. When the oldest slot holds its result, it retires. A register operation writes the register file. A store writes memory at the address recorded at issue. A branch writes nothing, unless it was mispredicted. A mispredicted branch discards every younger slot, clears the rename table, raises a one-cycle flush to the reservation stations, and presents the correct target on the redirect output.

Top module: `spec_rob`

## Requirements
- R1: The buffer holds `DEPTH` slots (default 8) in a circle. Slots are allocated in order from a tail pointer and retired in order from a head pointer. An occupancy count tells full from empty. After the last slot the pointers wrap to slot 0.
- R2: `issue_ready_o` is high only when a slot is free, `rs_free_i` is high and no flush is under way. An `issue_valid_i` seen while `issue_ready_o` is low allocates nothing and leaves the rename table unchanged.
- R3: `issue_tag_o` is the index of the slot the next issue takes. Issuing a register operation (`issue_kind_i` = 0) points that destination register's rename entry at the slot. After that, `src_busy_o` is 1 and `src_tag_o` is the slot for that register.
- R4: A result-bus beat (`cdb_valid_i`) whose tag names an occupied slot stores `cdb_value_i` and `cdb_mispred_i` in that slot and marks it ready.
- R5: Only the head slot retires, and only once it is ready. Ready younger slots wait, and while the head waits no commit output is raised.
- R6: At retirement, a register op (kind 0) raises `reg_we_o` with its register and value. A store (kind 1) raises `st_we_o` with the issue-time address and the result value as data. A correctly predicted branch (kind 2) raises no write and no flush. Each retirement is visible for the one cycle before the clock edge that frees the slot.
- R7: A branch that retires with its mispredict bit set raises `flush_o` for that cycle and drives `redirect_o` with its result value. No write is raised in that cycle. After the edge the buffer is empty, every younger slot is discarded even if ready, all rename entries are clear, and the next tag is the slot just past the branch.
- R8: When a register op retires, its register's rename entry is cleared only if it still names the retiring slot. An entry that points at a younger slot stays.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_valid_i | input | 1 | Issue request |
| issue_kind_i | input | 2 | 0 register op, 1 store, 2 branch |
| issue_reg_i | input | REG_W | Destination register of a register op |
| issue_addr_i | input | ADDR_W | Store address |
| rs_free_i | input | 1 | A reservation station is free |
| issue_ready_o | output | 1 | Issue accepted this cycle when valid |
| issue_tag_o | output | TAG_W | Slot taken by the next issue |
| src_reg_i | input | REG_W | Register to look up in the rename table |
| src_busy_o | output | 1 | Looked-up register awaits a slot |
| src_tag_o | output | TAG_W | Slot the looked-up register awaits |
| cdb_valid_i | input | 1 | Result-bus beat |
| cdb_tag_i | input | TAG_W | Slot the result belongs to |
| cdb_value_i | input | DATA_W | Result value or branch target |
| cdb_mispred_i | input | 1 | Branch was mispredicted |
| reg_we_o | output | 1 | Register file write |
| reg_waddr_o | output | REG_W | Register written |
| reg_wdata_o | output | DATA_W | Value written |
| st_we_o | output | 1 | Memory store |
| st_addr_o | output | ADDR_W | Store address |
| st_data_o | output | DATA_W | Store data |
| flush_o | output | 1 | Discard all speculative work |
| redirect_o | output | ADDR_W | Restart address |

## Verification
The assertions assume that the result bus names only slots that are occupied and not yet ready, that each slot gets at most one beat, and that `cdb_mispred_i` is set only for branch slots. The bench drives each tag exactly once after its issue and sets the mispredict bit only on branch beats. It holds `issue_valid_i` high against a full buffer and against a busy reservation station, checking that the rename table shows no effect. The wraparound sweep keeps at most one instruction in flight, so every tag it drives belongs to the single live slot.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    KIND_REG    = 2'd0,
    KIND_STORE  = 2'd1,
    KIND_BRANCH = 2'd2
  } rob_kind_e;
endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs #(
  parameter int DEPTH = 8,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alloc_i,
  input  logic             commit_i,
  input  logic             flush_i,
  output logic [TAG_W-1:0] head_o,
  output logic [TAG_W-1:0] tail_o,
  output logic             full_o
);
  logic [TAG_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] count_q;

  function automatic logic [TAG_W-1:0] inc(input logic [TAG_W-1:0] p);
    return (p == TAG_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else if (flush_i) begin
      // branch retires, everything younger is dropped
      head_q  <= inc(head_q);
      tail_q  <= inc(head_q);
      count_q <= '0;
    end else begin
      if (commit_i) head_q <= inc(head_q);
      if (alloc_i)  tail_q <= inc(tail_q);
      count_q <= count_q + CNT_W'(alloc_i) - CNT_W'(commit_i);
    end
  end

  assign head_o = head_q;
  assign tail_o = tail_q;
  assign full_o = (count_q == CNT_W'(DEPTH));

  // R1
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !commit_i) |-> !alloc_i);
  // R1
  count_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CNT_W'(DEPTH));
  // R7
  flush_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (count_q == '0) && (head_q == tail_q));
  // R5
  no_commit_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |-> (count_q != '0));
endmodule

// File: rtl/rob_entries.sv
module rob_entries
  import rob_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int REG_W  = 5,
  localparam int TAG_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_i,
  input  logic [TAG_W-1:0]  tail_i,
  input  rob_kind_e         kind_i,
  input  logic [REG_W-1:0]  reg_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              cdb_valid_i,
  input  logic [TAG_W-1:0]  cdb_tag_i,
  input  logic [DATA_W-1:0] cdb_value_i,
  input  logic              cdb_mispred_i,
  input  logic              commit_i,
  input  logic              flush_i,
  input  logic [TAG_W-1:0]  head_i,
  output logic              head_valid_o,
  output logic              head_ready_o,
  output logic              head_mispred_o,
  output rob_kind_e         head_kind_o,
  output logic [REG_W-1:0]  head_reg_o,
  output logic [ADDR_W-1:0] head_addr_o,
  output logic [DATA_W-1:0] head_value_o
);
  logic              valid_q   [DEPTH];
  logic              ready_q   [DEPTH];
  logic              mispred_q [DEPTH];
  rob_kind_e         kind_q    [DEPTH];
  logic [REG_W-1:0]  reg_q     [DEPTH];
  logic [ADDR_W-1:0] addr_q    [DEPTH];
  logic [DATA_W-1:0] value_q   [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    localparam logic [TAG_W-1:0] IDX = TAG_W'(i);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[i]   <= 1'b0;
        ready_q[i]   <= 1'b0;
        mispred_q[i] <= 1'b0;
        kind_q[i]    <= KIND_REG;
        reg_q[i]     <= '0;
        addr_q[i]    <= '0;
        value_q[i]   <= '0;
      end else if (flush_i) begin
        valid_q[i] <= 1'b0;
        ready_q[i] <= 1'b0;
      end else if (alloc_i && tail_i == IDX) begin
        valid_q[i]   <= 1'b1;
        ready_q[i]   <= 1'b0;
        mispred_q[i] <= 1'b0;
        kind_q[i]    <= kind_i;
        reg_q[i]     <= reg_i;
        addr_q[i]    <= addr_i;
      end else if (commit_i && head_i == IDX) begin
        valid_q[i] <= 1'b0;
        ready_q[i] <= 1'b0;
      end else if (cdb_valid_i && cdb_tag_i == IDX && valid_q[i]) begin
        ready_q[i]   <= 1'b1;
        value_q[i]   <= cdb_value_i;
        mispred_q[i] <= cdb_mispred_i;
      end
    end
  end

  assign head_valid_o   = valid_q[head_i];
  assign head_ready_o   = ready_q[head_i];
  assign head_mispred_o = mispred_q[head_i];
  assign head_kind_o    = kind_q[head_i];
  assign head_reg_o     = reg_q[head_i];
  assign head_addr_o    = addr_q[head_i];
  assign head_value_o   = value_q[head_i];

  // R4
  cdb_live_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cdb_valid_i |-> valid_q[cdb_tag_i] && !ready_q[cdb_tag_i]);
  // R4
  cdb_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cdb_valid_i && !flush_i && !(commit_i && head_i == cdb_tag_i)
     && valid_q[cdb_tag_i]) |=> ready_q[$past(cdb_tag_i)]);
  // R3
  alloc_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |-> !valid_q[tail_i]);
  // R6
  mispred_branch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cdb_valid_i && cdb_mispred_i) |-> kind_q[cdb_tag_i] == KIND_BRANCH);
endmodule

// File: rtl/rob_rename.sv
module rob_rename #(
  parameter int NUM_REGS = 32,
  parameter int TAG_W    = 3,
  localparam int REG_W   = $clog2(NUM_REGS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic [REG_W-1:0] set_reg_i,
  input  logic [TAG_W-1:0] set_tag_i,
  input  logic             clr_i,
  input  logic [REG_W-1:0] clr_reg_i,
  input  logic [TAG_W-1:0] clr_tag_i,
  input  logic             flush_i,
  input  logic [REG_W-1:0] look_reg_i,
  output logic             look_busy_o,
  output logic [TAG_W-1:0] look_tag_o
);
  logic             busy_q [NUM_REGS];
  logic [TAG_W-1:0] tag_q  [NUM_REGS];

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    localparam logic [REG_W-1:0] RID = REG_W'(r);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        busy_q[r] <= 1'b0;
        tag_q[r]  <= '0;
      end else if (flush_i) begin
        busy_q[r] <= 1'b0;
      end else if (set_i && set_reg_i == RID) begin
        busy_q[r] <= 1'b1;
        tag_q[r]  <= set_tag_i;
      end else if (clr_i && clr_reg_i == RID && tag_q[r] == clr_tag_i) begin
        busy_q[r] <= 1'b0;
      end
    end
  end

  assign look_busy_o = busy_q[look_reg_i];
  assign look_tag_o  = tag_q[look_reg_i];

  // R3
  rename_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !flush_i) |=> busy_q[$past(set_reg_i)] && tag_q[$past(set_reg_i)] == $past(set_tag_i));
  // R8
  rename_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i && !flush_i && busy_q[clr_reg_i] && tag_q[clr_reg_i] != clr_tag_i)
    |=> busy_q[$past(clr_reg_i)]);
  // R7
  rename_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !busy_q[$past(look_reg_i)]);
endmodule

// File: rtl/spec_rob.sv
module spec_rob
  import rob_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 32,
  localparam int TAG_W   = $clog2(DEPTH),
  localparam int REG_W   = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_valid_i,
  input  logic [1:0]        issue_kind_i,
  input  logic [REG_W-1:0]  issue_reg_i,
  input  logic [ADDR_W-1:0] issue_addr_i,
  input  logic              rs_free_i,
  output logic              issue_ready_o,
  output logic [TAG_W-1:0]  issue_tag_o,
  input  logic [REG_W-1:0]  src_reg_i,
  output logic              src_busy_o,
  output logic [TAG_W-1:0]  src_tag_o,
  input  logic              cdb_valid_i,
  input  logic [TAG_W-1:0]  cdb_tag_i,
  input  logic [DATA_W-1:0] cdb_value_i,
  input  logic              cdb_mispred_i,
  output logic              reg_we_o,
  output logic [REG_W-1:0]  reg_waddr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic              st_we_o,
  output logic [ADDR_W-1:0] st_addr_o,
  output logic [DATA_W-1:0] st_data_o,
  output logic              flush_o,
  output logic [ADDR_W-1:0] redirect_o
);
  logic [TAG_W-1:0]  head, tail;
  logic              full, alloc, commit, flush;
  logic              head_valid, head_ready, head_mispred;
  rob_kind_e         head_kind, issue_kind;
  logic [REG_W-1:0]  head_reg;
  logic [ADDR_W-1:0] head_addr;
  logic [DATA_W-1:0] head_value;

  assign issue_kind    = rob_kind_e'(issue_kind_i);
  assign commit        = head_valid && head_ready;
  assign flush         = commit && head_kind == KIND_BRANCH && head_mispred;
  assign issue_ready_o = !full && rs_free_i && !flush;
  assign alloc         = issue_valid_i && issue_ready_o;
  assign issue_tag_o   = tail;

  rob_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk_i, .rst_ni,
    .alloc_i (alloc),
    .commit_i(commit),
    .flush_i (flush),
    .head_o  (head),
    .tail_o  (tail),
    .full_o  (full)
  );

  rob_entries #(.DEPTH(DEPTH), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .REG_W(REG_W)) u_entries (
    .clk_i, .rst_ni,
    .alloc_i       (alloc),
    .tail_i        (tail),
    .kind_i        (issue_kind),
    .reg_i         (issue_reg_i),
    .addr_i        (issue_addr_i),
    .cdb_valid_i, .cdb_tag_i, .cdb_value_i, .cdb_mispred_i,
    .commit_i      (commit),
    .flush_i       (flush),
    .head_i        (head),
    .head_valid_o  (head_valid),
    .head_ready_o  (head_ready),
    .head_mispred_o(head_mispred),
    .head_kind_o   (head_kind),
    .head_reg_o    (head_reg),
    .head_addr_o   (head_addr),
    .head_value_o  (head_value)
  );

  rob_rename #(.NUM_REGS(NUM_REGS), .TAG_W(TAG_W)) u_rename (
    .clk_i, .rst_ni,
    .set_i      (alloc && issue_kind == KIND_REG),
    .set_reg_i  (issue_reg_i),
    .set_tag_i  (tail),
    .clr_i      (commit && head_kind == KIND_REG),
    .clr_reg_i  (head_reg),
    .clr_tag_i  (head),
    .flush_i    (flush),
    .look_reg_i (src_reg_i),
    .look_busy_o(src_busy_o),
    .look_tag_o (src_tag_o)
  );

  assign reg_we_o    = commit && head_kind == KIND_REG;
  assign reg_waddr_o = head_reg;
  assign reg_wdata_o = head_value;
  assign st_we_o     = commit && head_kind == KIND_STORE;
  assign st_addr_o   = head_addr;
  assign st_data_o   = head_value;
  assign flush_o     = flush;
  assign redirect_o  = head_value;

  // R6
  one_action_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({reg_we_o, st_we_o, flush_o}));
  // R2
  no_issue_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> !alloc);
  // R2
  issue_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rs_free_i |-> !issue_ready_o);
endmodule

// File: tb/tb_spec_rob.sv
`timescale 1ns/1ps
module tb_spec_rob;
  localparam int DEPTH = 4, NREG = 8, DW = 16, AW = 16;
  localparam int TW = $clog2(DEPTH), RW = $clog2(NREG);

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic issue_valid_i, rs_free_i, cdb_valid_i, cdb_mispred_i;
  logic [1:0] issue_kind_i;
  logic [RW-1:0] issue_reg_i, src_reg_i, reg_waddr_o;
  logic [AW-1:0] issue_addr_i, st_addr_o, redirect_o;
  logic [TW-1:0] issue_tag_o, src_tag_o, cdb_tag_i;
  logic [DW-1:0] cdb_value_i, reg_wdata_o, st_data_o;
  logic issue_ready_o, src_busy_o, reg_we_o, st_we_o, flush_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int exp_tag;

  always #2.5 clk_i = ~clk_i;

  spec_rob #(.DEPTH(DEPTH), .NUM_REGS(NREG), .DATA_W(DW), .ADDR_W(AW)) dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    #1;
  endtask

  task automatic idle();
    issue_valid_i = 0; issue_kind_i = 0; issue_reg_i = 0; issue_addr_i = 0;
    cdb_valid_i = 0; cdb_tag_i = 0; cdb_value_i = 0; cdb_mispred_i = 0;
  endtask

  task automatic issue(input logic [1:0] k, input int r, input int a);
    issue_valid_i = 1; issue_kind_i = k; issue_reg_i = RW'(r); issue_addr_i = AW'(a);
  endtask

  task automatic cdb(input int t, input int v, input bit mp);
    cdb_valid_i = 1; cdb_tag_i = TW'(t); cdb_value_i = DW'(v); cdb_mispred_i = mp;
  endtask

  task automatic no_commit(input string req);
    chk(req, {reg_we_o, st_we_o, flush_o}, 3'b000);
  endtask

  task automatic look(input string req, input int r, input bit busy, input int tag);
    src_reg_i = RW'(r); #0.1;
    chk(req, src_busy_o, busy);
    if (busy) chk(req, src_tag_o, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    idle(); rs_free_i = 0; src_reg_i = 0;
    #12 rst_ni = 1;
    step();
    // reset state
    no_commit("R1 reset");
    chk("R3 reset tag", issue_tag_o, 0);
    look("R3 reset rename", 1, 0, 0);
    // R2 no free reservation station
    chk("R2 rs busy", issue_ready_o, 0);
    issue(0, 6, 0); step();
    rs_free_i = 1; idle();
    chk("R2 blocked tag", issue_tag_o, 0);
    look("R2 blocked rename", 6, 0, 0);
    // fill: r1 t0, r2 t1, r3 t2, r1 t3
    for (int i = 0; i < DEPTH; i++) begin
      issue(0, (i == 3) ? 1 : i + 1, 0);
      chk("R3 tag seq", issue_tag_o, i);
      step();
    end
    idle();
    chk("R1 full", issue_ready_o, 0);
    look("R3 rename r1", 1, 1, 3);
    look("R3 rename r2", 2, 1, 1);
    issue(0, 6, 0); step(); idle();
    look("R2 full ignored", 6, 0, 0);
    // out-of-order completion
    cdb(2, 'h33, 0); step(); idle();
    no_commit("R5 head not ready");
    cdb(0, 'h11, 0); step(); idle();
    chk("R6 reg we", reg_we_o, 1);
    chk("R6 reg addr", reg_waddr_o, 1);
    chk("R4 reg data", reg_wdata_o, 'h11);
    cdb(1, 'h22, 0); step(); idle();
    look("R8 keep younger", 1, 1, 3);
    chk("R6 reg addr 2", reg_waddr_o, 2);
    chk("R6 reg data 2", reg_wdata_o, 'h22);
    step();
    chk("R5 waiting younger commit", reg_waddr_o, 3);
    chk("R4 stored early", reg_wdata_o, 'h33);
    step();
    no_commit("R5 head3 pending");
    look("R8 cleared r2", 2, 0, 0);
    chk("R1 space", issue_ready_o, 1);
    // wraparound: store t0, branch t1, r5 t2
    issue(1, 0, 'h100); chk("R1 wrap tag", issue_tag_o, 0); step();
    issue(2, 0, 0);     chk("R3 branch tag", issue_tag_o, 1); step();
    issue(0, 5, 0);     chk("R3 r5 tag", issue_tag_o, 2); step();
    idle();
    chk("R1 full again", issue_ready_o, 0);
    look("R3 rename r5", 5, 1, 2);
    cdb(3, 'h44, 0); step(); idle();
    chk("R6 r1 commit", {reg_we_o, reg_waddr_o}, {1'b1, 3'd1});
    cdb(0, 'hAB, 0); step(); idle();
    look("R8 cleared r1", 1, 0, 0);
    chk("R6 store we", {st_we_o, reg_we_o}, 2'b10);
    chk("R6 store addr", st_addr_o, 'h100);
    chk("R6 store data", st_data_o, 'hAB);
    cdb(2, 'h55, 0); step(); idle();
    no_commit("R5 branch pending");
    cdb(1, 'h200, 1); step(); idle();
    chk("R7 flush", flush_o, 1);
    chk("R7 redirect", redirect_o, 'h200);
    chk("R7 no write", {reg_we_o, st_we_o}, 2'b00);
    chk("R2 no issue in flush", issue_ready_o, 0);
    step();
    no_commit("R7 younger dropped");
    look("R7 rename cleared", 5, 0, 0);
    chk("R7 tail after branch", issue_tag_o, 2);
    chk("R7 empty", issue_ready_o, 1);
    // correctly predicted branch
    issue(2, 0, 0); step(); idle();
    cdb(2, 'h300, 0); step(); idle();
    no_commit("R6 good branch");
    step();
    no_commit("R6 good branch gone");
    // sweep: single instruction in flight around the ring
    exp_tag = 3;
    for (int i = 0; i < 3 * DEPTH * NREG; i++) begin
      int r = i % NREG;
      int v = (i * 37 + 5) % 65536;
      issue(0, r, 0);
      chk("R1 sweep tag", issue_tag_o, exp_tag);
      step(); idle();
      look("R3 sweep rename", r, 1, exp_tag);
      cdb(exp_tag, v, 0); step(); idle();
      chk("R6 sweep we", reg_we_o, 1);
      chk("R6 sweep addr", reg_waddr_o, r);
      chk("R4 sweep data", reg_wdata_o, v);
      step();
      look("R8 sweep clear", r, 0, 0);
      exp_tag = (exp_tag + 1) % DEPTH;
    end
    finish_run();
  end
endmodule